// File: doc/BRIEF.md
# Vector Compare and Mask Unit

This block builds a one-bit-per-element predicate mask for a vector datapath. A compare command selects a relation and either a second vector stream or a scalar operand. The unit then takes elements one per accepted cycle, as signed 64-bit integers, and writes one mask bit for each element below the current vector length. Mask bits at or above that length keep their old value. The same mask register can be filled with ones, loaded from a 64-bit scalar, read out as a 64-bit scalar, or reduced to a count of its set bits.

Commands arrive on a single command port and are taken only while the unit is idle. A small controller walks each compare through three states. IDLE waits for a command. COMPARE consumes elements and advances an element index whenever `elem_valid` is high. FINISH lasts one cycle and raises `cmp_done`. The transitions are:

- IDLE to COMPARE when a compare is accepted with a non-zero length.
- IDLE to FINISH when a compare is accepted with a length of zero.
- COMPARE to FINISH when the last element is consumed.
- FINISH to IDLE, always.

Top module: `vmask_unit`

## Requirements
- R1: `cmd_rel` selects the relation as a signed test of A against B: 0 equal, 1 not equal, 2 greater, 3 less, 4 greater-or-equal, 5 less-or-equal. Codes 6 and 7 never hold, so they write 0 bits.
- R2: A compare is command `cmd_op`=0 (two vectors). For that command, mask bit i becomes 1 exactly when the relation holds between the i-th accepted `elem_a` and `elem_b`, and becomes 0 otherwise.
- R3: Command `cmd_op`=1 (vector against scalar) captures `scalar_in` at acceptance. It uses that value as B for every element, and `elem_b` has no effect.
- R4: A compare writes only bits 0 to vlen-1, and all higher mask bits stay unchanged. With a length of 0, the compare changes no bit and still raises `cmp_done`.
- R5: `len_we` while idle loads `len_in` into the length register, and values above 64 are clamped to 64. `len_we` while busy is ignored. `vlen_out` shows the register.
- R6: Command `cmd_op`=2 requests a count of ones. `pop_valid` is high for exactly the cycle after acceptance, with `pop_count` equal to the number of 1 bits in the mask at acceptance.
- R7: Command `cmd_op`=3 sets all 64 mask bits to 1 on the following cycle.
- R8: Command `cmd_op`=4 copies `scalar_in` into the mask. `mask_out` always shows the mask, which gives the copy in the other direction. Codes 5 to 7 do nothing.
- R9: `busy` is high from the cycle after a compare is accepted through the one-cycle `cmp_done` pulse. While busy, `cmd_valid` is ignored. Elements are consumed only on cycles with `elem_valid` high.
- R10: After reset the mask is all zeros, the length is 64, and `busy`, `cmp_done` and `pop_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code |
| cmd_rel | input | 3 | Relation code for compares |
| scalar_in | input | 64 | Scalar operand or mask load value |
| len_we | input | 1 | Length register write |
| len_in | input | 7 | New vector length |
| elem_valid | input | 1 | Element pair present |
| elem_a | input | 64 | Element A, signed |
| elem_b | input | 64 | Element B, signed |
| busy | output | 1 | Compare in progress |
| cmp_done | output | 1 | One-cycle compare completion pulse |
| mask_out | output | 64 | Current mask register |
| vlen_out | output | 7 | Current vector length |
| pop_valid | output | 1 | Count result strobe |
| pop_count | output | 7 | Number of ones in the mask |

## Verification
The assertions check, on every cycle, the properties that can be stated locally:

- The element index stays below the length, and the length never exceeds 64.
- Mask bits above the length stay still during a compare, and the length stays still while busy.
- FINISH lasts exactly one cycle.
- Fill-with-ones, load and count requests take effect on the next cycle.

Only the bench scenarios can show that each relation gives the right signed result for real data, including extreme values. They also show that a scalar compare ignores `elem_b`, that gaps in `elem_valid` do not shift bit positions, and that a command or length write issued mid-compare leaves the final mask untouched.

// File: rtl/vmask_pkg.sv
package vmask_pkg;

    typedef enum logic [2:0] {
        OP_CMP_VV  = 3'd0,
        OP_CMP_VS  = 3'd1,
        OP_POPCNT  = 3'd2,
        OP_SETALL  = 3'd3,
        OP_LDMASK  = 3'd4,
        OP_NOP5    = 3'd5,
        OP_NOP6    = 3'd6,
        OP_NOP7    = 3'd7
    } vm_op_e;

    typedef enum logic [2:0] {
        REL_EQ  = 3'd0,
        REL_NE  = 3'd1,
        REL_GT  = 3'd2,
        REL_LT  = 3'd3,
        REL_GE  = 3'd4,
        REL_LE  = 3'd5,
        REL_RS6 = 3'd6,
        REL_RS7 = 3'd7
    } vm_rel_e;

    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_COMPARE = 2'd1,
        S_FINISH  = 2'd2
    } vm_state_e;

endpackage

// File: rtl/vmask_relcmp.sv
module vmask_relcmp
    import vmask_pkg::*;
#(
    parameter int ELEM_W = 64
) (
    input  logic [ELEM_W-1:0] opa,
    input  logic [ELEM_W-1:0] opb,
    input  vm_rel_e           rel,
    output logic              hit
);

    logic signed [ELEM_W-1:0] sa;
    logic signed [ELEM_W-1:0] sb;
    logic                     eq;
    logic                     lt;

    assign sa = opa;
    assign sb = opb;
    assign eq = (sa == sb);
    assign lt = (sa < sb);

    always_comb begin
        unique case (rel)
            REL_EQ:  hit = eq;
            REL_NE:  hit = !eq;
            REL_GT:  hit = !lt && !eq;
            REL_LT:  hit = lt;
            REL_GE:  hit = !lt;
            REL_LE:  hit = lt || eq;
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/vmask_popcnt.sv
module vmask_popcnt #(
    parameter int N     = 64,
    parameter int CNT_W = $clog2(N + 1)
) (
    input  logic [N-1:0]     bits,
    output logic [CNT_W-1:0] count
);

    always_comb begin
        count = '0;
        for (int i = 0; i < N; i++) begin
            count = count + CNT_W'(bits[i]);
        end
    end

endmodule

// File: rtl/vmask_ctrl.sv
module vmask_ctrl
    import vmask_pkg::*;
#(
    parameter int MAX_LEN = 64,
    localparam int LEN_W  = $clog2(MAX_LEN + 1),
    localparam int IDX_W  = $clog2(MAX_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_cmp,
    input  logic [LEN_W-1:0] vlen,
    input  logic             elem_valid,
    output vm_state_e        state,
    output logic [IDX_W-1:0] idx,
    output logic             wr_en,
    output logic             busy,
    output logic             cmp_done
);

    vm_state_e        state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             last_elem;

    assign last_elem = (LEN_W'(idx_q) == (vlen - LEN_W'(1)));

    // state and index register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            S_IDLE: begin
                idx_d = '0;
                if (start_cmp) begin
                    state_d = (vlen == '0) ? S_FINISH : S_COMPARE;
                end
            end
            S_COMPARE: begin
                if (elem_valid) begin
                    idx_d = idx_q + IDX_W'(1);
                    if (last_elem) begin
                        state_d = S_FINISH;
                    end
                end
            end
            S_FINISH: begin
                state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        wr_en    = 1'b0;
        busy     = 1'b0;
        cmp_done = 1'b0;
        unique case (state_q)
            S_IDLE: ;
            S_COMPARE: begin
                busy  = 1'b1;
                wr_en = elem_valid;
            end
            S_FINISH: begin
                busy     = 1'b1;
                cmp_done = 1'b1;
            end
            default: ;
        endcase
    end

    assign state = state_q;
    assign idx   = idx_q;

    // R4: the index never reaches the length while comparing
    a_r4_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_COMPARE) |-> (LEN_W'(idx_q) < vlen));

    // R9: the completion state lasts one cycle
    a_r9_finish_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FINISH) |=> (state_q == S_IDLE));

    // R4: a zero-length compare goes straight to completion
    a_r4_zero_len_finish: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && start_cmp && vlen == '0) |=> (state_q == S_FINISH));

endmodule

// File: rtl/vmask_unit.sv
module vmask_unit
    import vmask_pkg::*;
#(
    parameter int ELEM_W  = 64,
    parameter int MAX_LEN = 64,
    localparam int LEN_W  = $clog2(MAX_LEN + 1),
    localparam int IDX_W  = $clog2(MAX_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [2:0]        cmd_rel,
    input  logic [ELEM_W-1:0] scalar_in,
    input  logic              len_we,
    input  logic [LEN_W-1:0]  len_in,
    input  logic              elem_valid,
    input  logic [ELEM_W-1:0] elem_a,
    input  logic [ELEM_W-1:0] elem_b,
    output logic              busy,
    output logic              cmp_done,
    output logic [MAX_LEN-1:0] mask_out,
    output logic [LEN_W-1:0]  vlen_out,
    output logic              pop_valid,
    output logic [LEN_W-1:0]  pop_count
);

    vm_op_e             op;
    logic               accept;
    logic               start_cmp;
    vm_state_e          state;
    logic [IDX_W-1:0]   idx;
    logic               wr_en;
    logic               hit;
    logic [ELEM_W-1:0]  opb;
    logic [LEN_W-1:0]   pop_now;

    logic [MAX_LEN-1:0] mask_q, mask_d;
    logic [LEN_W-1:0]   vlen_q;
    vm_rel_e            rel_q;
    logic               vs_q;
    logic [ELEM_W-1:0]  scal_q;
    logic               pop_valid_q;
    logic [LEN_W-1:0]   pop_count_q;
    logic [MAX_LEN-1:0] low_bits;

    assign op        = vm_op_e'(cmd_op);
    assign accept    = cmd_valid && !busy;
    assign start_cmp = accept && (op == OP_CMP_VV || op == OP_CMP_VS);

    vmask_ctrl #(.MAX_LEN(MAX_LEN)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_cmp  (start_cmp),
        .vlen       (vlen_q),
        .elem_valid (elem_valid),
        .state      (state),
        .idx        (idx),
        .wr_en      (wr_en),
        .busy       (busy),
        .cmp_done   (cmp_done)
    );

    assign opb = vs_q ? scal_q : elem_b;

    vmask_relcmp #(.ELEM_W(ELEM_W)) u_cmp (
        .opa (elem_a),
        .opb (opb),
        .rel (rel_q),
        .hit (hit)
    );

    vmask_popcnt #(.N(MAX_LEN), .CNT_W(LEN_W)) u_pop (
        .bits  (mask_q),
        .count (pop_now)
    );

    // compare setup captured at acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rel_q  <= REL_EQ;
            vs_q   <= 1'b0;
            scal_q <= '0;
        end else if (start_cmp) begin
            rel_q  <= vm_rel_e'(cmd_rel);
            vs_q   <= (op == OP_CMP_VS);
            scal_q <= scalar_in;
        end
    end

    // length register, clamped
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vlen_q <= LEN_W'(MAX_LEN);
        end else if (len_we && !busy) begin
            vlen_q <= (len_in > LEN_W'(MAX_LEN)) ? LEN_W'(MAX_LEN) : len_in;
        end
    end

    // mask next value
    always_comb begin
        mask_d = mask_q;
        if (wr_en) begin
            mask_d[idx] = hit;
        end
        if (accept && op == OP_SETALL) begin
            mask_d = '1;
        end
        if (accept && op == OP_LDMASK) begin
            mask_d = scalar_in[MAX_LEN-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q      <= '0;
            pop_valid_q <= 1'b0;
            pop_count_q <= '0;
        end else begin
            mask_q      <= mask_d;
            pop_valid_q <= accept && (op == OP_POPCNT);
            if (accept && op == OP_POPCNT) begin
                pop_count_q <= pop_now;
            end
        end
    end

    assign mask_out  = mask_q;
    assign vlen_out  = vlen_q;
    assign pop_valid = pop_valid_q;
    assign pop_count = pop_count_q;

    // bits below the length, used by the checks only
    always_comb begin
        for (int i = 0; i < MAX_LEN; i++) begin
            low_bits[i] = (i < int'(vlen_q));
        end
    end

    a_r4_tail_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_COMPARE) |=> ((mask_q & ~low_bits) == ($past(mask_q) & ~low_bits)));

    a_r5_len_max: assert property (@(posedge clk) disable iff (!rst_n)
        vlen_q <= LEN_W'(MAX_LEN));

    a_r5_len_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && len_we) |=> $stable(vlen_q));

    a_r6_pop_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op == OP_POPCNT) |=> (pop_valid && pop_count == $past(pop_now)));

    a_r6_pop_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pop_valid |-> (pop_count <= LEN_W'(MAX_LEN)));

    a_r7_setall: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op == OP_SETALL) |=> (&mask_q));

    a_r8_load: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op == OP_LDMASK) |=> (mask_q == $past(scalar_in[MAX_LEN-1:0])));

    a_r9_idle_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !wr_en) |=> $stable(mask_q));

endmodule

// File: tb/vmask_unit_tb.sv
`timescale 1ns/1ps
module vmask_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [2:0]  cmd_rel = '0;
    logic [63:0] scalar_in = '0;
    logic        len_we = 1'b0;
    logic [6:0]  len_in = '0;
    logic        elem_valid = 1'b0;
    logic [63:0] elem_a = '0;
    logic [63:0] elem_b = '0;
    logic        busy, cmp_done, pop_valid;
    logic [63:0] mask_out;
    logic [6:0]  vlen_out, pop_count;

    int n_chk = 0;
    int n_bad = 0;
    logic [63:0] exp_m = '0;
    int          exp_len = 64;
    logic [63:0] q_mask[$];
    int          q_pop[$];

    always #10 clk = ~clk;

    vmask_unit u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_rel(cmd_rel), .scalar_in(scalar_in), .len_we(len_we), .len_in(len_in),
        .elem_valid(elem_valid), .elem_a(elem_a), .elem_b(elem_b), .busy(busy),
        .cmp_done(cmp_done), .mask_out(mask_out), .vlen_out(vlen_out),
        .pop_valid(pop_valid), .pop_count(pop_count)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit rel_ok(input logic [2:0] r, input logic signed [63:0] a,
                                  input logic signed [63:0] b);
        case (r)
            3'd0: return a == b;
            3'd1: return a != b;
            3'd2: return a > b;
            3'd3: return a < b;
            3'd4: return a >= b;
            3'd5: return a <= b;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [63:0] gen_a(input int i, input int s);
        if (i == 0) return 64'h8000_0000_0000_0000;
        if (i == 1) return 64'h7fff_ffff_ffff_ffff;
        return 64'(signed'(((i * 37 + s) % 11) - 5));
    endfunction

    function automatic logic [63:0] gen_b(input int i, input int s);
        if (i == 0) return 64'h7fff_ffff_ffff_ffff;
        if (i == 1) return 64'h7fff_ffff_ffff_ffff;
        return 64'(signed'(((i * 13 + s) % 7) - 3));
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (cmp_done) begin
                if (q_mask.size() == 0) check(0, "R9 unexpected cmp_done", 64'd1, 64'd0);
                else begin
                    logic [63:0] e;
                    e = q_mask.pop_front();
                    check(mask_out == e, "R2/R4 compare mask", mask_out, e);
                end
            end
            if (pop_valid) begin
                if (q_pop.size() == 0) check(0, "R6 unexpected pop_valid", 64'd1, 64'd0);
                else begin
                    int e;
                    e = q_pop.pop_front();
                    check(int'(pop_count) == e, "R6 pop count", 64'(pop_count), 64'(e));
                end
            end
        end
    end

    task automatic simple_cmd(input logic [2:0] op, input logic [63:0] s);
        @(negedge clk);
        if (op == 3'd2) q_pop.push_back($countones(exp_m));
        if (op == 3'd3) exp_m = '1;
        if (op == 3'd4) exp_m = s;
        cmd_valid = 1'b1; cmd_op = op; scalar_in = s;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic set_len(input int l);
        @(negedge clk);
        len_we = 1'b1; len_in = 7'(l);
        exp_len = (l > 64) ? 64 : l;
        @(negedge clk);
        len_we = 1'b0;
    endtask

    // driver: compare with gaps and optional mid-run disturbance
    task automatic run_cmp(input bit vs, input logic [2:0] rel, input logic [63:0] s,
                           input int seed, input bit gaps, input bit disturb);
        for (int i = 0; i < exp_len; i++) begin
            logic [63:0] b;
            b = vs ? s : gen_b(i, seed);
            exp_m[i] = rel_ok(rel, gen_a(i, seed), b);
        end
        q_mask.push_back(exp_m);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = vs ? 3'd1 : 3'd0; cmd_rel = rel; scalar_in = s;
        for (int i = 0; i < exp_len; i++) begin
            @(negedge clk);
            cmd_valid = 1'b0;
            len_we = 1'b0;
            if (gaps && (i % 3 == 1)) begin
                elem_valid = 1'b0; elem_a = 64'd5; elem_b = 64'd5;
                @(negedge clk);
            end
            if (disturb && i == 2) begin
                cmd_valid = 1'b1; cmd_op = 3'd3;
                len_we = 1'b1; len_in = 7'd3;
            end
            elem_valid = 1'b1;
            elem_a = gen_a(i, seed);
            elem_b = vs ? ~s : gen_b(i, seed);
        end
        @(negedge clk);
        cmd_valid = 1'b0; len_we = 1'b0; elem_valid = 1'b0;
        while (busy) @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        check(0, "watchdog", 64'd0, 64'd1);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check(mask_out == 64'd0, "R10 reset mask", mask_out, 64'd0);
        check(vlen_out == 7'd64, "R10 reset length", 64'(vlen_out), 64'd64);
        check(!busy && !cmp_done && !pop_valid, "R10 reset strobes",
              {61'd0, busy, cmp_done, pop_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1, R2: every relation at full length
        for (int r = 0; r < 6; r++) run_cmp(0, 3'(r), 64'd0, r, 0, 0);
        // R1: reserved codes give zeros
        run_cmp(0, 3'd6, 64'd0, 1, 0, 0);
        check(mask_out == 64'd0, "R1 code 6 zero", mask_out, 64'd0);
        run_cmp(0, 3'd7, 64'd0, 2, 0, 0);

        // R3: scalar against every element, elem_b is inverted junk
        run_cmp(1, 3'd4, 64'd1, 3, 0, 0);
        run_cmp(1, 3'd3, 64'hffff_ffff_ffff_fffe, 4, 1, 0);

        // R7, R4, R5: fill then short compare
        simple_cmd(3'd3, 64'd0);
        check(mask_out == '1, "R7 set all", mask_out, '1);
        set_len(10);
        check(vlen_out == 7'd10, "R5 length write", 64'(vlen_out), 64'd10);
        run_cmp(0, 3'd2, 64'd0, 5, 0, 0);
        check(mask_out[63:10] == '1, "R4 tail kept", 64'(mask_out[63:10]), 64'h3f_ffff_ffff_ffff);
        set_len(100);
        check(vlen_out == 7'd64, "R5 clamp", 64'(vlen_out), 64'd64);

        // R4: zero length compare
        simple_cmd(3'd4, 64'hdead_beef_0123_4567);
        check(mask_out == 64'hdead_beef_0123_4567, "R8 load mask", mask_out,
              64'hdead_beef_0123_4567);
        set_len(0);
        run_cmp(0, 3'd0, 64'd0, 6, 0, 0);
        check(mask_out == 64'hdead_beef_0123_4567, "R4 zero length", mask_out,
              64'hdead_beef_0123_4567);

        // R6: population counts
        simple_cmd(3'd2, 64'd0);
        simple_cmd(3'd4, 64'd0);
        simple_cmd(3'd2, 64'd0);
        simple_cmd(3'd3, 64'd0);
        simple_cmd(3'd2, 64'd0);

        // R8: ops 5..7 do nothing
        simple_cmd(3'd5, 64'd0);
        simple_cmd(3'd7, 64'd0);
        check(mask_out == '1, "R8 nop codes", mask_out, '1);

        // R9: gaps and disturbance while busy
        set_len(20);
        run_cmp(0, 3'd1, 64'd0, 7, 1, 1);
        check(vlen_out == 7'd20, "R9 length write ignored while busy", 64'(vlen_out), 64'd20);
        check(mask_out[63:20] == '1, "R9 command ignored while busy",
              64'(mask_out[63:20]), 64'h0fff_ffff_ffff);

        repeat (3) @(negedge clk);
        check(q_mask.size() == 0 && q_pop.size() == 0, "R9 all results seen",
              64'(q_mask.size() + q_pop.size()), 64'd0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule